// File: doc/BRIEF.md
# Pixel-Sequential LED Matrix Scanner

This block drives an LED matrix built from row lines and column lines, lighting at most one LED at any moment. Time is cut into equal pixel slots. In each slot the block switches on the row line of one logical pixel and pulses that pixel's column line. The pulse width is the pixel's 8-bit brightness value multiplied by a time unit derived from the clock rate, the refresh rate and the pixel count. Pixels are visited in index order and the sequence wraps after the last one.

A configuration table gives each logical pixel one byte. The upper nibble of the byte is the row line index and the lower nibble is the column line index. Each row and column line also has its own byte: the low seven bits pick the physical output pin, and the top bit makes the line active-low. Brightness values are fetched through a synchronous single-port read interface with one cycle of latency. Two pulse inputs stop the scan (blank) and restart it (unblank). The block leaves reset blanked.

Top module: `led_matrix_scanner`

## Requirements
- R1: Pixel i drives the row line given by bits [7:4] of its mapping byte and the column line given by bits [3:0].
- R2: If any mapping byte has a row index >= NUM_ROWS or a column index >= NUM_COLS, or any line byte selects a pin >= the pin count, then after the next clock edge `cfg_err` is 1 and every line is inactive. When the configuration becomes valid again, the lines return on the next edge.
- R3: One time unit U equals CLK_HZ / (REFRESH_HZ * NUM_PIX * 255) cycles and must be at least 1. A slot lasts 255*U cycles, a count that must fit in 16 bits (checked at elaboration). The row line is active for the first 255*U-1 cycles of the slot.
- R4: The column line is active from the first cycle of the slot for min(v*U, 255*U-1) cycles, where v is the pixel's brightness value. When v = 0 the column stays inactive for the whole slot.
- R5: Slots show pixels 0, 1, ..., NUM_PIX-1 in that order, then return to 0.
- R6: In a line byte, bit 7 = 1 means active-low (inactive level 1) and bits [6:0] give the physical pin. Any pin that no line selects is driven 0.
- R7: At most one row line and one column line are active at once. The last cycle of every slot has all lines inactive, so the rows break before they make.
- R8: A `blank_set` pulse makes every line inactive after the next clock edge and stops the scan. The pulse has no effect when the block is already blanked.
- R9: A `blank_clr` pulse while blanked restarts the scan. Pixel 0's slot starts on the third clock edge after the edge that samples the pulse, and all lines stay inactive until then. `blank_clr` while the scan runs is ignored. When both pulses arrive together, blanking wins.
- R10: During and after reset the block is blanked, all pins are at their inactive levels, `fb_rd` is 0 and `cfg_err` is 0.
- R11: `fb_rd` is high for one cycle, in the cycle that is three cycles before a slot boundary, with `fb_addr` set to the next pixel. `fb_data` is taken in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank_set | input | 1 | Pulse: stop the scan and darken all lines |
| blank_clr | input | 1 | Pulse: restart the scan from pixel 0 |
| map_cfg | input | NUM_PIX*8 | Per-pixel bytes, row index [7:4], column index [3:0]; pixel 0 in the low byte |
| row_cfg | input | NUM_ROWS*8 | Per-row-line bytes, active-low bit 7, pin select [6:0] |
| col_cfg | input | NUM_COLS*8 | Per-column-line bytes, active-low bit 7, pin select [6:0] |
| fb_rd | output | 1 | Framebuffer read strobe |
| fb_addr | output | PIX_W | Framebuffer read address |
| fb_data | input | 8 | Framebuffer read data, one cycle after `fb_rd` |
| row_pins | output | ROW_PINS | Registered physical row outputs |
| col_pins | output | COL_PINS | Registered physical column outputs |
| cfg_err | output | 1 | Registered invalid-configuration flag |

## Verification
After a `blank_clr` edge, the fetch strobe appears in the next cycle, and the first row appears three edges later. The bench then samples at every falling edge across each 255-cycle slot and compares each cycle's pin levels with the expected pulse window for the pixel, so the pulse width, the row window and the dark last cycle are each checked at the exact cycle count. Blanking and configuration errors act one edge after they are applied, and the bench checks them at the first falling edge after that edge. A `blank_clr` pulse in the middle of a slot must leave the slot sequence unchanged, and the bench confirms this by measuring the next two slots.

// File: rtl/lms_pkg.sv
package lms_pkg;
   localparam int unsigned BRIGHT_STEPS = 255;
   localparam int unsigned LINE_CFG_W   = 8;
   localparam int unsigned POL_BIT      = 7;
   localparam int unsigned PIN_SEL_W    = 7;
   localparam int unsigned IDX_W        = 4;
   localparam int unsigned FETCH_LEAD   = 3;

   function automatic int unsigned unit_cycles(input int unsigned clk_hz,
                                               input int unsigned refresh_hz,
                                               input int unsigned npix);
      return clk_hz / (refresh_hz * npix * BRIGHT_STEPS);
   endfunction
endpackage

// File: rtl/lms_cfg_check.sv
module lms_cfg_check
   import lms_pkg::*;
#(
   parameter int NUM_PIX  = 6,
   parameter int NUM_ROWS = 3,
   parameter int NUM_COLS = 4,
   parameter int ROW_PINS = 4,
   parameter int COL_PINS = 5
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PIX*LINE_CFG_W-1:0]  map_cfg,
   input  logic [NUM_ROWS*LINE_CFG_W-1:0] row_cfg,
   input  logic [NUM_COLS*LINE_CFG_W-1:0] col_cfg,
   output logic                         cfg_bad,
   output logic                         cfg_err_q
);
   logic [NUM_PIX-1:0]  pix_bad;
   logic [NUM_ROWS-1:0] row_bad;
   logic [NUM_COLS-1:0] col_bad;

   for (genvar i = 0; i < NUM_PIX; i++) begin : g_pix
      logic [IDX_W-1:0] r_idx, c_idx;
      assign r_idx = map_cfg[i*LINE_CFG_W+IDX_W +: IDX_W];
      assign c_idx = map_cfg[i*LINE_CFG_W +: IDX_W];
      assign pix_bad[i] = (32'(r_idx) >= NUM_ROWS) || (32'(c_idx) >= NUM_COLS);
   end

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      assign row_bad[r] = 32'(row_cfg[r*LINE_CFG_W +: PIN_SEL_W]) >= ROW_PINS;
   end

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign col_bad[c] = 32'(col_cfg[c*LINE_CFG_W +: PIN_SEL_W]) >= COL_PINS;
   end

   assign cfg_bad = (|pix_bad) || (|row_bad) || (|col_bad);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_err_q <= 1'b0;
      else        cfg_err_q <= cfg_bad;
   end
endmodule

// File: rtl/lms_slot_timer.sv
module lms_slot_timer
   import lms_pkg::*;
#(
   parameter int NUM_PIX = 6,
   parameter int UNIT    = 1,
   localparam int SLOT   = BRIGHT_STEPS * UNIT,
   localparam int CNT_W  = $clog2(SLOT + 1),
   localparam int PIX_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             blank_set,
   input  logic             blank_clr,
   output logic             fb_rd,
   output logic [PIX_W-1:0] fb_addr,
   input  logic [7:0]       fb_data,
   output logic [PIX_W-1:0] pix_n,
   output logic             row_en_n,
   output logic             col_en_n
);
   localparam logic [PIX_W-1:0] LAST_PIX  = PIX_W'(NUM_PIX - 1);
   localparam logic [CNT_W-1:0] T_END     = CNT_W'(SLOT - 1);
   localparam logic [CNT_W-1:0] T_CAPTURE = CNT_W'(SLOT - 2);
   localparam logic [CNT_W-1:0] T_FETCH   = CNT_W'(SLOT - FETCH_LEAD);

   logic             running, running_n;
   logic             lit, lit_n;
   logic [CNT_W-1:0] tcnt, tcnt_n;
   logic [PIX_W-1:0] pix, pix_succ;
   logic [CNT_W-1:0] pulse, pulse_n;
   logic [7:0]       val_q, val_n;

   assign pix_succ = (pix == LAST_PIX) ? '0 : pix + 1'b1;

   always_comb begin
      running_n = running;
      lit_n     = lit;
      tcnt_n    = tcnt;
      pix_n     = pix;
      pulse_n   = pulse;
      val_n     = val_q;
      if (blank_set) begin
         running_n = 1'b0;
         lit_n     = 1'b0;
      end else if (!running) begin
         if (blank_clr) begin
            running_n = 1'b1;
            lit_n     = 1'b0;
            tcnt_n    = T_FETCH;
            pix_n     = LAST_PIX;
         end
      end else begin
         if (tcnt == T_CAPTURE) val_n = fb_data;
         if (tcnt == T_END) begin
            tcnt_n  = '0;
            pix_n   = pix_succ;
            pulse_n = CNT_W'(32'(val_q) * UNIT);
            lit_n   = 1'b1;
         end else begin
            tcnt_n = tcnt + 1'b1;
         end
      end
   end

   assign row_en_n = running_n && lit_n && (tcnt_n != T_END);
   assign col_en_n = row_en_n && (tcnt_n < pulse_n);

   assign fb_rd   = running && (tcnt == T_FETCH);
   assign fb_addr = pix_succ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         lit     <= 1'b0;
         tcnt    <= '0;
         pix     <= '0;
         pulse   <= '0;
         val_q   <= '0;
      end else begin
         running <= running_n;
         lit     <= lit_n;
         tcnt    <= tcnt_n;
         pix     <= pix_n;
         pulse   <= pulse_n;
         val_q   <= val_n;
      end
   end

   // R5: the pixel index moves only at a slot boundary
   a_r5_pix_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && (tcnt != T_END) && !blank_set) |=> $stable(pix));

   // R11: fetch address always names an existing pixel
   a_r11_fetch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      fb_rd |-> (32'(fb_addr) < NUM_PIX));

   // R8: a blank request halts the slot counter on the next cycle
   a_r8_halt: assert property (@(posedge clk) disable iff (!rst_n)
      blank_set |=> !running);
endmodule

// File: rtl/lms_line_drive.sv
module lms_line_drive
   import lms_pkg::*;
#(
   parameter int NUM_PIX  = 6,
   parameter int NUM_ROWS = 3,
   parameter int NUM_COLS = 4,
   localparam int PIX_W   = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PIX*LINE_CFG_W-1:0] map_cfg,
   input  logic [PIX_W-1:0]              pix_n,
   input  logic                          row_en_n,
   input  logic                          col_en_n,
   input  logic                          force_dark,
   output logic [NUM_ROWS-1:0]           row_act_n,
   output logic [NUM_COLS-1:0]           col_act_n,
   output logic [NUM_ROWS-1:0]           row_act_q,
   output logic [NUM_COLS-1:0]           col_act_q
);
   logic [LINE_CFG_W-1:0] entry;
   assign entry = map_cfg[int'(pix_n)*LINE_CFG_W +: LINE_CFG_W];

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      assign row_act_n[r] = row_en_n && !force_dark &&
                            (32'(entry[LINE_CFG_W-1 -: IDX_W]) == r);
   end

   for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      assign col_act_n[c] = col_en_n && !force_dark &&
                            (32'(entry[IDX_W-1:0]) == c);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_act_q <= '0;
         col_act_q <= '0;
      end else begin
         row_act_q <= row_act_n;
         col_act_q <= col_act_n;
      end
   end

   // R7: never more than one row or one column line on
   a_r7_one_row: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_act_q));
   a_r7_one_col: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_act_q));
   // R7: a lit row is followed by itself or by darkness, never by another row
   a_r7_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
      (row_act_q != '0) |=> ((row_act_q == '0) || (row_act_q == $past(row_act_q))));
   // R4: a column pulse only happens inside a lit row window
   a_r4_col_needs_row: assert property (@(posedge clk) disable iff (!rst_n)
      (col_act_q != '0) |-> (row_act_q != '0));
endmodule

// File: rtl/lms_pin_map.sv
module lms_pin_map
   import lms_pkg::*;
#(
   parameter int LINES = 3,
   parameter int PINS  = 4
)(
   input  logic                        clk,
   input  logic [LINES*LINE_CFG_W-1:0] line_cfg,
   input  logic [LINES-1:0]            line_act_n,
   output logic [PINS-1:0]             pins_q
);
   logic [PINS-1:0] pins_n;

   always_comb begin
      pins_n = '0;
      for (int l = 0; l < LINES; l++) begin
         for (int p = 0; p < PINS; p++) begin
            if (32'(line_cfg[l*LINE_CFG_W +: PIN_SEL_W]) == p)
               pins_n[p] = pins_n[p] |
                           (line_act_n[l] ^ line_cfg[l*LINE_CFG_W + POL_BIT]);
         end
      end
   end

   always_ff @(posedge clk) pins_q <= pins_n;
endmodule

// File: rtl/led_matrix_scanner.sv
module led_matrix_scanner
   import lms_pkg::*;
#(
   parameter int NUM_PIX    = 6,
   parameter int NUM_ROWS   = 3,
   parameter int NUM_COLS   = 4,
   parameter int ROW_PINS   = 4,
   parameter int COL_PINS   = 5,
   parameter int CLK_HZ     = 16_000_000,
   parameter int REFRESH_HZ = 10_000,
   localparam int PIX_W     = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           blank_set,
   input  logic                           blank_clr,
   input  logic [NUM_PIX*LINE_CFG_W-1:0]  map_cfg,
   input  logic [NUM_ROWS*LINE_CFG_W-1:0] row_cfg,
   input  logic [NUM_COLS*LINE_CFG_W-1:0] col_cfg,
   output logic                           fb_rd,
   output logic [PIX_W-1:0]               fb_addr,
   input  logic [7:0]                     fb_data,
   output logic [ROW_PINS-1:0]            row_pins,
   output logic [COL_PINS-1:0]            col_pins,
   output logic                           cfg_err
);
   localparam int UNIT = int'(unit_cycles(CLK_HZ, REFRESH_HZ, NUM_PIX));
   localparam int SLOT = BRIGHT_STEPS * UNIT;

   if (UNIT < 1) begin : g_err_unit
      $error("time unit below one clock cycle");
   end
   if (SLOT > 65535) begin : g_err_slot
      $error("pixel slot does not fit in 16 bits");
   end
   if (NUM_ROWS > 16 || NUM_COLS > 16 || NUM_PIX < 1) begin : g_err_lines
      $error("line counts must fit a nibble index");
   end
   if (ROW_PINS > 128 || COL_PINS > 128) begin : g_err_pins
      $error("pin count exceeds the pin select field");
   end

   logic                cfg_bad;
   logic [PIX_W-1:0]    pix_n;
   logic                row_en_n, col_en_n;
   logic [NUM_ROWS-1:0] row_act_n, row_act_q;
   logic [NUM_COLS-1:0] col_act_n, col_act_q;

   lms_cfg_check #(
      .NUM_PIX(NUM_PIX), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS),
      .ROW_PINS(ROW_PINS), .COL_PINS(COL_PINS)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .map_cfg(map_cfg), .row_cfg(row_cfg),
      .col_cfg(col_cfg), .cfg_bad(cfg_bad), .cfg_err_q(cfg_err)
   );

   lms_slot_timer #(.NUM_PIX(NUM_PIX), .UNIT(UNIT)) i_timer (
      .clk(clk), .rst_n(rst_n), .blank_set(blank_set), .blank_clr(blank_clr),
      .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_data(fb_data),
      .pix_n(pix_n), .row_en_n(row_en_n), .col_en_n(col_en_n)
   );

   lms_line_drive #(.NUM_PIX(NUM_PIX), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) i_lines (
      .clk(clk), .rst_n(rst_n), .map_cfg(map_cfg), .pix_n(pix_n),
      .row_en_n(row_en_n), .col_en_n(col_en_n), .force_dark(cfg_bad || !rst_n),
      .row_act_n(row_act_n), .col_act_n(col_act_n),
      .row_act_q(row_act_q), .col_act_q(col_act_q)
   );

   lms_pin_map #(.LINES(NUM_ROWS), .PINS(ROW_PINS)) i_row_pins (
      .clk(clk), .line_cfg(row_cfg), .line_act_n(row_act_n), .pins_q(row_pins)
   );

   lms_pin_map #(.LINES(NUM_COLS), .PINS(COL_PINS)) i_col_pins (
      .clk(clk), .line_cfg(col_cfg), .line_act_n(col_act_n), .pins_q(col_pins)
   );

   // R8: the cycle after a blank request has no active line
   a_r8_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
      blank_set |=> ((row_act_q == '0) && (col_act_q == '0)));
   // R2: a flagged configuration keeps every line off
   a_r2_err_dark: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> ((row_act_q == '0) && (col_act_q == '0)));
endmodule

// File: tb/test_led_matrix_scanner.sv
module test_led_matrix_scanner;
   localparam int NPIX = 6, NR = 3, NC = 4, RP = 4, CP = 5;
   localparam logic [3:0] IDLE_ROW = 4'b0001;
   localparam logic [4:0] IDLE_COL = 5'b11000;
   localparam logic [NPIX*8-1:0] MAP  = {8'h23, 8'h10, 8'h02, 8'h21, 8'h13, 8'h00};
   localparam logic [NR*8-1:0]   ROWC = {8'h03, 8'h80, 8'h02};
   localparam logic [NC*8-1:0]   COLC = {8'h83, 8'h00, 8'h01, 8'h84};
   localparam int ROW_PIN [NR] = '{2, 0, 3};
   localparam int ROW_POL [NR] = '{0, 1, 0};
   localparam int COL_PIN [NC] = '{4, 1, 0, 3};
   localparam int COL_POL [NC] = '{1, 0, 0, 1};
   localparam logic [7:0] FBV [NPIX] = '{8'd0, 8'd1, 8'd100, 8'd255, 8'd254, 8'd37};

   typedef struct packed { int row; int col; int width; } vec_t;
   // one entry per slot: expected row line, column line, pulse width (U = 1)
   localparam vec_t VEC [7] = '{
      '{0, 0, 0}, '{1, 3, 1}, '{2, 1, 100}, '{0, 2, 254},
      '{1, 0, 254}, '{2, 3, 37}, '{0, 0, 0}};

   logic clk = 1'b0, rst_n = 1'b0, blank_set = 1'b0, blank_clr = 1'b0;
   logic [NPIX*8-1:0] map_cfg = MAP;
   logic [NR*8-1:0]   row_cfg = ROWC;
   logic [NC*8-1:0]   col_cfg = COLC;
   logic fb_rd, cfg_err;
   logic [2:0] fb_addr;
   logic [7:0] fb_data = 8'd0;
   logic [RP-1:0] row_pins;
   logic [CP-1:0] col_pins;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   always_ff @(posedge clk) if (fb_rd) fb_data <= FBV[fb_addr];

   led_matrix_scanner #(.NUM_PIX(NPIX), .NUM_ROWS(NR), .NUM_COLS(NC),
      .ROW_PINS(RP), .COL_PINS(CP), .CLK_HZ(16_000_000), .REFRESH_HZ(10_000)
   ) i_led_matrix_scanner (
      .clk(clk), .rst_n(rst_n), .blank_set(blank_set), .blank_clr(blank_clr),
      .map_cfg(map_cfg), .row_cfg(row_cfg), .col_cfg(col_cfg),
      .fb_rd(fb_rd), .fb_addr(fb_addr), .fb_data(fb_data),
      .row_pins(row_pins), .col_pins(col_pins), .cfg_err(cfg_err));

   task automatic chk(input string what, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic bit dark();
      return (row_pins === IDLE_ROW) && (col_pins === IDLE_COL);
   endfunction

   // walk one slot starting just after its first edge
   task automatic run_slot(input int v, input bit poke);
      int rp = ROW_PIN[VEC[v].row], rpol = ROW_POL[VEC[v].row];
      int cp = COL_PIN[VEC[v].col], cpol = COL_POL[VEC[v].col];
      int rows_on = 0, col_bad = 0, other_bad = 0;
      bit gap_ok = 1'b0;
      for (int k = 0; k < 255; k++) begin
         @(negedge clk);
         if ((row_pins[rp] ^ rpol[0]) == 1'b1) rows_on++;
         if (((col_pins[cp] ^ cpol[0]) == 1'b1) != (k < VEC[v].width)) col_bad++;
         if ((row_pins | RP'(1 << rp)) != (IDLE_ROW | RP'(1 << rp))) other_bad++;
         if ((col_pins | CP'(1 << cp)) != (IDLE_COL | CP'(1 << cp))) other_bad++;
         if (k == 254) gap_ok = dark();
         if (poke) blank_clr = (k == 50);
         @(posedge clk);
      end
      chk($sformatf("R1 R3 R5 R6 row window slot %0d", v), rows_on == 254, rows_on, 254);
      chk($sformatf("R4 R6 column pulse slot %0d", v), col_bad == 0, col_bad, 0);
      chk($sformatf("R7 R6 other lines idle slot %0d", v), other_bad == 0, other_bad, 0);
      chk($sformatf("R7 dark gap slot %0d", v), gap_ok, gap_ok, 1);
   endtask

   task automatic unblank_align();
      @(negedge clk); blank_clr = 1'b1;
      @(posedge clk);
      @(negedge clk); blank_clr = 1'b0;
      chk("R11 fetch strobe", fb_rd === 1'b1, fb_rd, 1);
      chk("R11 fetch address pixel 0", fb_addr === 3'd0, fb_addr, 0);
      chk("R9 dark before first slot", dark(), row_pins, IDLE_ROW);
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk("R9 still dark two edges later", dark(), row_pins, IDLE_ROW);
      @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int idle_bad;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R10 pins idle in reset", dark(), row_pins, IDLE_ROW);
      chk("R10 no fetch in reset", fb_rd === 1'b0, fb_rd, 0);
      chk("R10 no error in reset", cfg_err === 1'b0, cfg_err, 0);
      rst_n = 1'b1;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R10 blanked after reset", dark(), col_pins, IDLE_COL);

      // table walk: full frame plus wrap to pixel 0
      unblank_align();
      for (int v = 0; v < 7; v++) run_slot(v, 1'b0);
      // R9: blank_clr while running is ignored, sequence continues
      run_slot(1, 1'b1);
      run_slot(2, 1'b0);

      // R8: blank in the middle of pixel 3
      repeat (10) @(posedge clk);
      @(negedge clk); blank_set = 1'b1;
      @(posedge clk);
      @(negedge clk); blank_set = 1'b0;
      chk("R8 dark after blank", dark(), row_pins, IDLE_ROW);
      idle_bad = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (!dark()) idle_bad++;
      end
      chk("R8 stays dark while blanked", idle_bad == 0, idle_bad, 0);
      @(negedge clk); blank_set = 1'b1;
      @(posedge clk);
      @(negedge clk); blank_set = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R8 second blank no effect", dark() && fb_rd === 1'b0, row_pins, IDLE_ROW);

      // R9: restart begins from pixel 0
      unblank_align();
      run_slot(0, 1'b0);
      run_slot(1, 1'b0);

      // R9: simultaneous pulses, blanking wins
      repeat (20) @(posedge clk);
      @(negedge clk); blank_set = 1'b1; blank_clr = 1'b1;
      @(posedge clk);
      @(negedge clk); blank_set = 1'b0; blank_clr = 1'b0;
      chk("R9 blank wins over restart", dark(), row_pins, IDLE_ROW);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk("R9 remains blanked", dark() && fb_rd === 1'b0, row_pins, IDLE_ROW);

      // R2: configuration faults during pixel 0
      unblank_align();
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R1 pixel 0 row lit", row_pins[2] === 1'b1, row_pins[2], 1);
      map_cfg[7:0] = 8'h30;
      @(posedge clk); @(negedge clk);
      chk("R2 row index at limit flagged", cfg_err === 1'b1, cfg_err, 1);
      chk("R2 lines dark on error", dark(), row_pins, IDLE_ROW);
      map_cfg[7:0] = 8'h00;
      @(posedge clk); @(negedge clk);
      chk("R2 error clears", cfg_err === 1'b0, cfg_err, 0);
      chk("R2 row returns", row_pins[2] === 1'b1, row_pins[2], 1);
      map_cfg[7:0] = 8'h14;
      @(posedge clk); @(negedge clk);
      chk("R2 column index at limit flagged", cfg_err === 1'b1, cfg_err, 1);
      map_cfg[7:0] = 8'h00;
      row_cfg[7:0] = 8'h04;
      @(posedge clk); @(negedge clk);
      chk("R2 pin select at limit flagged", cfg_err === 1'b1, cfg_err, 1);
      chk("R2 lines dark on pin fault", dark(), row_pins, IDLE_ROW);
      row_cfg[7:0] = 8'h02;
      @(posedge clk); @(negedge clk);
      chk("R2 pin fault clears", cfg_err === 1'b0 && row_pins[2] === 1'b1, cfg_err, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule